// File: doc/BRIEF.md
# Buffered Block Serial Sender for Multi-Channel ECG Samples

The block gathers filtered samples from several ECG channels, about 100 Hz per channel, into a 256-byte ring memory. Once a block of 42 sample sets has been stored, it raises an interrupt toward the host microcontroller. The host then clocks the whole block out over a synchronous serial line in one burst. Because the burst is short compared with the time needed to fill a block, the link is idle most of the time.

Each sample is stored either as two bytes, high byte first, or as its upper byte alone. A resolution input picks between the two. The choice is taken when a block begins and applies to the whole block. New samples keep going into the ring while an earlier block is being shifted out. The serial clock comes from the host and is oversampled by the block's own clock. Data is presented MSB first, changes after a falling serial clock edge and is meant to be sampled on the rising edge.

Top module: `ecg_blk_sender`

## Requirements
- R1: After a synchronous active-low reset, `irq_o`, `frame_o` and `sdo_o` are all low.
- R2: With `res16_i` high when a block begins, every sample takes two consecutive bytes (bits 15:8, then bits 7:0), and a block is BLK_SETS*NUM_CH*2 bytes (252 with defaults).
- R3: With `res16_i` low when a block begins, only bits 15:8 of each sample are stored, and a block is BLK_SETS*NUM_CH bytes (126 with defaults).
- R4: Samples are stored in the order their strobes arrive. Strobes raised in the same cycle are stored in increasing channel index (channel 0 is bits 15:0 of `smp_data_i`).
- R5: `irq_o` rises only after the last byte of a block has been stored. It stays low while that block is still incomplete.
- R6: `irq_o` falls at the first rising serial clock edge of the transfer. `frame_o` is high from that edge until the falling edge after the block's final bit, and then returns low with `sdo_o` low.
- R7: The bytes of a block leave MSB first and in storage order. `sdo_o` changes only after falling serial clock edges, so it is stable across each rising edge.
- R8: Serial clock activity while no block is announced is ignored: `sdo_o` and `frame_o` stay low and no stored byte is consumed.
- R9: Samples are accepted while a transfer is in progress. Blocks wrap around the end of the 256-byte ring without corrupting any byte.
- R10: The resolution is sampled only while no byte of the current block is stored. A change made in the middle of a block takes effect at the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld_i | input | NUM_CH | One strobe per channel; a new sample is present |
| smp_data_i | input | NUM_CH*16 | Packed 16-bit samples, channel 0 in the low bits |
| res16_i | input | 1 | 1: two bytes per sample, 0: upper byte only |
| sclk_i | input | 1 | Serial clock driven by the host, idle low |
| sdo_o | output | 1 | Serial data, MSB first |
| frame_o | output | 1 | High while a block is being shifted |
| irq_o | output | 1 | Block ready; cleared by the first serial clock rise |

## Verification
The bench goes after the block boundary. It checks that the interrupt is still low after 41 sets and high after the 42nd; a design that miscounts would announce a block early or late and shift out a byte that is wrong or missing. It flips the resolution in the middle of a block, which a design that samples the mode continuously would catch by mixing byte formats within one block. It feeds samples during a transfer and runs a block across the end of the ring, where a wrong pointer or fill count would corrupt bytes that have not yet been read. It also toggles the serial clock while nothing is announced and uses staggered strobes, which would expose a shifter that consumes bytes spuriously or a packer that reorders channels.

// File: rtl/ecgbs_pkg.sv
// Shared types for the block serial sender.
// Assumes 16-bit samples and byte-wide storage.
package ecgbs_pkg;
    localparam int SMP_W = 16;
    typedef logic [7:0] byte_t;
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_ARMED = 2'd1,
        SH_SHIFT = 2'd2
    } sh_state_t;
endpackage

// File: rtl/ecgbs_packer.sv
// Sample packer: latches per-channel samples on their strobes and emits
// them as a byte stream, one byte per cycle, lowest pending channel first.
// In 16-bit mode the high byte is followed directly by the low byte.
// Assumes each channel strobes far less often than once per NUM_CH*2 cycles.
module ecgbs_packer
    import ecgbs_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       smp_vld_i,
    input  logic [NUM_CH*SMP_W-1:0] smp_data_i,
    input  logic                    mode16_i,
    output logic                    wr_en_o,
    output byte_t                   wr_byte_o
);
    localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [SMP_W-1:0] hold [NUM_CH];
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] clr;
    logic              half;
    logic [CHW-1:0]    cur;
    logic [CHW-1:0]    sel;
    logic              any;

    // Pick the lowest-index channel with a waiting sample.
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                sel = CHW'(i);
                any = 1'b1;
            end
        end
    end

    // Drive the byte write and decide which channel is released.
    always_comb begin
        wr_en_o   = 1'b0;
        wr_byte_o = '0;
        clr       = '0;
        if (half) begin
            wr_en_o   = 1'b1;
            wr_byte_o = hold[cur][7:0];
            clr[cur]  = 1'b1;
        end else if (any) begin
            wr_en_o   = 1'b1;
            wr_byte_o = hold[sel][SMP_W-1 -: 8];
            if (!mode16_i) clr[sel] = 1'b1;
        end
    end

    // Track whether the low byte of a sample is still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half <= 1'b0;
            cur  <= '0;
        end else if (half) begin
            half <= 1'b0;
        end else if (any) begin
            half <= mode16_i;
            cur  <= sel;
        end
    end

    // One holding register and pending flag per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[c] <= 1'b0;
                hold[c] <= '0;
            end else if (smp_vld_i[c]) begin
                pend[c] <= 1'b1;
                hold[c] <= smp_data_i[c*SMP_W +: SMP_W];
            end else if (clr[c]) begin
                pend[c] <= 1'b0;
            end
        end
    end

    // R2: a high byte in 16-bit mode is always followed by its low byte.
    a_r2_low_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && mode16_i && !half) |=> wr_en_o);
endmodule

// File: rtl/ecgbs_ring.sv
// Byte ring memory: sequential writes, sequential reads and a fill count.
// The read port shows the byte at the read pointer without delay.
// Assumes the writer never gets ahead of the reader by a full ring.
module ecgbs_ring
    import ecgbs_pkg::*;
#(
    parameter int MEM_DEPTH = 256
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en_i,
    input  byte_t wr_byte_i,
    input  logic  rd_take_i,
    output byte_t rd_byte_o
);
    localparam int AW = $clog2(MEM_DEPTH);

    byte_t         mem [MEM_DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   fill;

    assign rd_byte_o = mem[rd_ptr];

    // Storage array write.
    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_ptr] <= wr_byte_i;
    end

    // Pointer and occupancy upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_en_i)   wr_ptr <= wr_ptr + 1'b1;
            if (rd_take_i) rd_ptr <= rd_ptr + 1'b1;
            case ({wr_en_i, rd_take_i})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // R9: a write never lands on a byte that has not been read yet.
    a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (fill < (AW+1)'(MEM_DEPTH)));
    // R9: a read never takes a byte that was never written.
    a_r9_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take_i |-> (fill != '0));
endmodule

// File: rtl/ecgbs_shifter.sv
// Serial shifter: oversamples the host serial clock, announces a finished
// block by interrupt, and shifts its bytes out MSB first. Data changes
// after falling edges and is held across rising edges.
// Assumes the serial clock stays low or high for at least SYNC_STAGES+2 clk.
module ecgbs_shifter
    import ecgbs_pkg::*;
#(
    parameter int LEN_W       = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             blk_done_i,
    input  logic [LEN_W-1:0] blk_len_i,
    input  byte_t            rd_byte_i,
    output logic             rd_take_o,
    output logic             sdo_o,
    output logic             frame_o,
    output logic             irq_o,
    output logic             idle_o
);
    logic [SYNC_STAGES-1:0] sync;
    logic                   prev;
    logic                   rise;
    logic                   fall;
    sh_state_t              st;
    byte_t                  sr;
    logic [3:0]             bitc;
    logic [LEN_W-1:0]       rem;
    logic                   byte_end;

    // Bring the host clock into this domain and keep one old sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync <= '0;
            prev <= 1'b0;
        end else begin
            sync <= {sync[SYNC_STAGES-2:0], sclk_i};
            prev <= sync[SYNC_STAGES-1];
        end
    end

    assign rise     = sync[SYNC_STAGES-1] & ~prev;
    assign fall     = ~sync[SYNC_STAGES-1] & prev;
    assign byte_end = (bitc == 4'd8);
    assign sdo_o    = sr[7];
    assign idle_o   = (st == SH_IDLE);
    assign rd_take_o = ((st == SH_IDLE) && blk_done_i) ||
                       ((st == SH_SHIFT) && fall && byte_end && (rem != '0));

    // Announce, start and run the transfer of one block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SH_IDLE;
            sr      <= '0;
            bitc    <= '0;
            rem     <= '0;
            irq_o   <= 1'b0;
            frame_o <= 1'b0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (blk_done_i) begin
                        sr    <= rd_byte_i;
                        rem   <= blk_len_i - 1'b1;
                        bitc  <= '0;
                        irq_o <= 1'b1;
                        st    <= SH_ARMED;
                    end
                end
                SH_ARMED: begin
                    if (rise) begin
                        irq_o   <= 1'b0;
                        frame_o <= 1'b1;
                        bitc    <= 4'd1;
                        st      <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (rise) begin
                        bitc <= bitc + 1'b1;
                    end else if (fall) begin
                        if (!byte_end) begin
                            sr <= {sr[6:0], 1'b0};
                        end else if (rem != '0) begin
                            sr   <= rd_byte_i;
                            rem  <= rem - 1'b1;
                            bitc <= '0;
                        end else begin
                            sr      <= '0;
                            frame_o <= 1'b0;
                            st      <= SH_IDLE;
                        end
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    // R6: the interrupt and the frame are never high together.
    a_r6_irq_frame_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && frame_o));
    // R6: a rising serial edge while announced clears the interrupt.
    a_r6_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && rise) |=> (!irq_o && frame_o));
    // R5: the interrupt rises only in answer to a completed block.
    a_r5_irq_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(blk_done_i));
    // R7: during a transfer the data line moves only after a falling edge.
    a_r7_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == SH_SHIFT) && !fall) |=> $stable(sdo_o));
endmodule

// File: rtl/ecg_blk_sender.sv
// Top of the block serial sender: packs channel samples into the ring,
// counts bytes per block, freezes the resolution for each block and hands
// completed blocks to the serial shifter.
// Assumes a block is fully shifted out before the next one completes.
module ecg_blk_sender
    import ecgbs_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int BLK_SETS    = 42,
    parameter int MEM_DEPTH   = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       smp_vld_i,
    input  logic [NUM_CH*SMP_W-1:0] smp_data_i,
    input  logic                    res16_i,
    input  logic                    sclk_i,
    output logic                    sdo_o,
    output logic                    frame_o,
    output logic                    irq_o
);
    localparam int LEN_W = $clog2(MEM_DEPTH + 1);
    localparam int LEN8  = BLK_SETS * NUM_CH;
    localparam int LEN16 = BLK_SETS * NUM_CH * 2;

    logic             wr_en;
    byte_t            wr_byte;
    logic             rd_take;
    byte_t            rd_byte;
    logic             blk_res;
    logic [LEN_W-1:0] blk_cnt;
    logic [LEN_W-1:0] blk_len;
    logic             blk_done;
    logic             sh_idle;

    assign blk_len  = blk_res ? LEN_W'(LEN16) : LEN_W'(LEN8);
    assign blk_done = wr_en && (blk_cnt == blk_len - 1'b1);

    // Count stored bytes and freeze the resolution until a block ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt <= '0;
            blk_res <= 1'b0;
        end else begin
            if (blk_done)   blk_cnt <= '0;
            else if (wr_en) blk_cnt <= blk_cnt + 1'b1;
            if ((blk_cnt == '0) && !wr_en) blk_res <= res16_i;
        end
    end

    ecgbs_packer #(.NUM_CH(NUM_CH)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld_i (smp_vld_i),
        .smp_data_i(smp_data_i),
        .mode16_i  (blk_res),
        .wr_en_o   (wr_en),
        .wr_byte_o (wr_byte)
    );

    ecgbs_ring #(.MEM_DEPTH(MEM_DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_byte_i(wr_byte),
        .rd_take_i(rd_take),
        .rd_byte_o(rd_byte)
    );

    ecgbs_shifter #(.LEN_W(LEN_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_i),
        .blk_done_i(blk_done),
        .blk_len_i (blk_len),
        .rd_byte_i (rd_byte),
        .rd_take_o (rd_take),
        .sdo_o     (sdo_o),
        .frame_o   (frame_o),
        .irq_o     (irq_o),
        .idle_o    (sh_idle)
    );

    // R5: a block completes only once the previous one has been sent.
    a_r5_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> sh_idle);
    // R10: the resolution of a block in progress never changes.
    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_cnt != '0) |-> (blk_res == $past(blk_res)));
endmodule

// File: tb/ecg_blk_sender_test.sv
module ecg_blk_sender_test;
    localparam int NCH  = 3;
    localparam int SETS = 42;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  smp_vld = '0;
    logic [NCH*16-1:0] smp_data = '0;
    logic            res16 = 1'b1;
    logic            sclk = 1'b0;
    logic            sdo, frame, irq;

    int checks = 0;
    int failures = 0;
    logic [7:0] expq [$];
    int  mdl_sets = 0;
    logic mdl_mode = 1'b1;

    always #2 clk = ~clk;

    ecg_blk_sender uut (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld), .smp_data_i(smp_data),
        .res16_i(res16), .sclk_i(sclk), .sdo_o(sdo), .frame_o(frame), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R6: interrupt and frame never overlap, checked on every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (irq && frame) begin
                failures++;
                $display("FAIL R6 actual=irq+frame expected=exclusive");
            end
        end
    end

    function automatic logic [15:0] pat(input int b, input int s, input int c);
        return {8'(b * 40 + s), 8'(c * 37 + s * 3 + 1)};
    endfunction

    // Reference model: append a sample in the resolution of its block.
    task automatic model_put(input logic [15:0] v);
        expq.push_back(v[15:8]);
        if (mdl_mode) expq.push_back(v[7:0]);
    endtask

    task automatic model_set_start();
        if (mdl_sets == 0) mdl_mode = res16;
    endtask

    task automatic model_set_end();
        mdl_sets++;
        if (mdl_sets == SETS) mdl_sets = 0;
    endtask

    // Present one sample set; R4 staggered order is ch2, ch0, ch1.
    task automatic push_set(input int b, input int s, input bit stagger);
        model_set_start();
        @(negedge clk);
        if (!stagger) begin
            for (int c = 0; c < NCH; c++) begin
                smp_data[c*16 +: 16] = pat(b, s, c);
                model_put(pat(b, s, c));
            end
            smp_vld = '1;
            @(negedge clk);
            smp_vld = '0;
        end else begin
            for (int k = 0; k < NCH; k++) begin
                int c = (k == 0) ? 2 : k - 1;
                smp_data[c*16 +: 16] = pat(b, s, c);
                model_put(pat(b, s, c));
                smp_vld = '0;
                smp_vld[c] = 1'b1;
                @(negedge clk);
                smp_vld = '0;
                repeat (4) @(negedge clk);
            end
        end
        repeat (12) @(negedge clk);
        model_set_end();
    endtask

    // Host side: shift one block out and compare against the model.
    task automatic read_block(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] got;
            logic [7:0] exp;
            for (int b = 7; b >= 0; b--) begin
                logic bitv;
                repeat (6) @(negedge clk);
                bitv = sdo;
                sclk = 1'b1;
                repeat (6) @(negedge clk);
                if (i == 0 && b == 7) begin
                    check("R6 irq cleared by first rise", irq, 0);
                    check("R6 frame high in transfer", frame, 1);
                end
                if (sdo !== bitv) begin
                    check("R7 sdo stable over rise", sdo, bitv);
                end
                got[b] = bitv;
                sclk = 1'b0;
            end
            exp = (expq.size() > 0) ? expq.pop_front() : 8'hxx;
            check(req, got, exp);
        end
        repeat (8) @(negedge clk);
        check("R6 frame low after block", frame, 0);
        check("R6 sdo low after block", sdo, 0);
    endtask

    task automatic toggle_idle(input int n);
        for (int k = 0; k < n; k++) begin
            repeat (5) @(negedge clk);
            sclk = 1'b1;
            repeat (5) @(negedge clk);
            check("R8 frame stays low", frame, 0);
            check("R8 sdo stays low", sdo, 0);
            sclk = 1'b0;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 irq at reset", irq, 0);
        check("R1 frame at reset", frame, 0);
        check("R1 sdo at reset", sdo, 0);

        // R8: serial clock with nothing announced.
        toggle_idle(10);
        check("R8 irq stays low", irq, 0);

        // Block 1, 16-bit (R2), coincident strobes (R4).
        res16 = 1'b1;
        for (int s = 0; s < SETS - 1; s++) push_set(1, s, 1'b0);
        check("R5 no irq before last set", irq, 0);
        push_set(1, SETS - 1, 1'b0);
        check("R5 irq after last set", irq, 1);
        check("R2 block length 16-bit", expq.size(), SETS * NCH * 2);

        // Block 2 (8-bit, R3) is partly filled during block 1 transfer (R9).
        res16 = 1'b0;
        fork
            read_block(SETS * NCH * 2, "R2 R7 16-bit byte");
            begin
                for (int s = 0; s < 10; s++) begin
                    push_set(2, s, s[0]);
                    if (s == 0) res16 = 1'b1;   // R10: mid-block change
                    repeat (1400) @(negedge clk);
                end
            end
        join
        for (int s = 10; s < SETS - 1; s++) push_set(2, s, 1'b0);
        check("R5 no irq before block 2 end", irq, 0);
        push_set(2, SETS - 1, 1'b0);
        check("R5 irq after block 2", irq, 1);
        check("R3 R10 block length 8-bit", expq.size(), SETS * NCH);
        read_block(SETS * NCH, "R3 R4 R10 8-bit byte");

        // Block 3, 16-bit after the change (R10), wraps the ring (R9).
        for (int s = 0; s < 20; s++) push_set(3, s, s[1]);
        toggle_idle(5);
        for (int s = 20; s < SETS; s++) push_set(3, s, 1'b0);
        check("R5 irq after block 3", irq, 1);
        read_block(SETS * NCH * 2, "R9 R10 R8 wrapped byte");
        check("R1 idle irq after all", irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule